// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps the per-line service state for a bank of active-high interrupt request lines. For each line it holds an enable flag, a pending flag and an active flag. It accepts both single-cycle pulses and held levels from peripherals, and it needs no per-line type setting. Software controls the block through per-line strobes that set or clear an enable and set or clear a pending flag. The core's exception sequencer reports handler entry (acknowledge) and handler exit (completion) by line number.

Each line runs a four-state machine with these states:

- `ST_IDLE`: not pending, not active.
- `ST_PEND`: pending, not active.
- `ST_ACT`: active, not pending.
- `ST_ACT_PEND`: active and pending again.

The transitions are:

- Arm: `ST_IDLE`→`ST_PEND`, on a request level or a software set.
- Drop: `ST_PEND`→`ST_IDLE`, on a software clear.
- Enter: `ST_PEND`→`ST_ACT`, on acknowledge.
- Repend: `ST_ACT`→`ST_ACT_PEND`, on a request rising edge or a software set.
- Unpend: `ST_ACT_PEND`→`ST_ACT`, on a software clear.
- Exit: `ST_ACT`→`ST_IDLE`, or `ST_ACT`→`ST_PEND` when the request is still high at exit.
- Exit-pending: `ST_ACT_PEND`→`ST_PEND`.

While a line is not active, a high request level arms it. While a line is active, only a rising edge arms it. Because of this, a level source that is still held at exit is re-armed at that moment.

The `ready_o` vector (pending and enabled) goes to a separate priority arbiter. Priority comparison and register addressing are outside this block.

Top module: `irq_pend_tracker`

## Requirements
- R1: After reset, `enable_o`, `pending_o`, `active_o` and `ready_o` are all zero.
- R2: `en_set[k]` sets the enable of line k at the next edge and `en_clr[k]` clears it; clear wins when both are given. `ready_o[k]` is 1 exactly when line k is both pending and enabled. Enable never changes the pending bit.
- R3: On a line that is not active, a request that is high for one cycle sets pending at the next clock edge, and pending stays set after the request falls.
- R4: Several request pulses before acknowledge leave a single pending bit. One acknowledge consumes it, and no second entry follows.
- R5: `pend_clr[k]` clears pending at the next edge and wins over a request, a software set or an acknowledge in the same cycle. If the request is still high, pending is set again one cycle later.
- R6: `pend_set[k]` sets pending without any request.
- R7: `ack_valid` with `ack_id`=k (binary line number), on a line that is pending and not active, clears pending and sets active at the same edge. An acknowledge on a line that is not pending, or is already active, has no effect.
- R8: While a line is active, a request held high does not set pending. A request rising edge or `pend_set` does set pending, and the active bit is unchanged.
- R9: `done_valid` with `done_id`=k clears active at the next edge. If the request is high in that cycle, pending is set at the same edge.
- R10: A completion on a line that is both active and pending clears active and keeps pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N | Active-high request lines |
| en_set | input | N | Per-line enable set strobes |
| en_clr | input | N | Per-line enable clear strobes |
| pend_set | input | N | Per-line software set-pending strobes |
| pend_clr | input | N | Per-line software clear-pending strobes |
| ack_valid | input | 1 | Handler entry strobe |
| ack_id | input | IDW | Line number being entered |
| done_valid | input | 1 | Handler exit strobe |
| done_id | input | IDW | Line number exiting |
| enable_o | output | N | Enable flags |
| pending_o | output | N | Pending flags |
| active_o | output | N | Active flags |
| ready_o | output | N | Pending and enabled, to the arbiter |

## Verification
Every output comes straight from a state register, so a wrong next-state decision shows at the ports one cycle after the stimulus that caused it.

- A lost edge-versus-level distinction shows up in two ways. A held level can re-pend an active line at once, or a line can fail to re-arm at exit. Each case appears on `pending_o` on the cycle after the entry or the exit.
- A wrong priority between clear and set shows as pending still high on the cycle after a clear.
- A mis-decoded acknowledge or completion shows as the wrong bit of `active_o` moving on the next edge.

// File: rtl/irq_trk_pkg.sv
`timescale 1ns/1ps
package irq_trk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PEND     = 2'd1,
        ST_ACT      = 2'd2,
        ST_ACT_PEND = 2'd3
    } line_state_t;
endpackage

// File: rtl/irq_id_decode.sv
`timescale 1ns/1ps
module irq_id_decode #(
    parameter int N   = 32,
    parameter int IDW = $clog2(N)
) (
    input  logic           valid_i,
    input  logic [IDW-1:0] id_i,
    output logic [N-1:0]   hit_o
);
    generate
        for (genvar k = 0; k < N; k++) begin : g_hit
            assign hit_o[k] = valid_i && (id_i == IDW'(k));
        end
    endgenerate
endmodule

// File: rtl/irq_enable_bank.sv
`timescale 1ns/1ps
module irq_enable_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] en_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o <= '0;
        end else begin
            en_o <= (en_o | set_i) & ~clr_i;
        end
    end
endmodule

// File: rtl/irq_line_fsm.sv
`timescale 1ns/1ps
module irq_line_fsm
    import irq_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic ack_i,
    input  logic done_i,
    output logic pend_o,
    output logic act_o
);
    line_state_t state_q, state_d;
    logic        req_q;
    logic        arm_level;
    logic        arm_edge;

    assign arm_level = req_i | set_i;
    assign arm_edge  = (req_i & ~req_q) | set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!clr_i && arm_level) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (clr_i)      state_d = ST_IDLE;
                else if (ack_i) state_d = ST_ACT;
            end
            ST_ACT: begin
                if (done_i)
                    state_d = (!clr_i && arm_level) ? ST_PEND : ST_IDLE;
                else if (!clr_i && arm_edge)
                    state_d = ST_ACT_PEND;
            end
            ST_ACT_PEND: begin
                if (done_i)     state_d = clr_i ? ST_IDLE : ST_PEND;
                else if (clr_i) state_d = ST_ACT;
            end
        endcase
    end

    always_comb begin
        pend_o = 1'b0;
        act_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:     begin pend_o = 1'b0; act_o = 1'b0; end
            ST_PEND:     begin pend_o = 1'b1; act_o = 1'b0; end
            ST_ACT:      begin pend_o = 1'b0; act_o = 1'b1; end
            ST_ACT_PEND: begin pend_o = 1'b1; act_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/irq_pend_tracker.sv
`timescale 1ns/1ps
module irq_pend_tracker #(
    parameter int N   = 32,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   irq_req,
    input  logic [N-1:0]   en_set,
    input  logic [N-1:0]   en_clr,
    input  logic [N-1:0]   pend_set,
    input  logic [N-1:0]   pend_clr,
    input  logic           ack_valid,
    input  logic [IDW-1:0] ack_id,
    input  logic           done_valid,
    input  logic [IDW-1:0] done_id,
    output logic [N-1:0]   enable_o,
    output logic [N-1:0]   pending_o,
    output logic [N-1:0]   active_o,
    output logic [N-1:0]   ready_o
);
    logic [N-1:0] ack_hit;
    logic [N-1:0] done_hit;

    irq_id_decode #(.N(N), .IDW(IDW)) u_ack_dec (
        .valid_i (ack_valid),
        .id_i    (ack_id),
        .hit_o   (ack_hit)
    );

    irq_id_decode #(.N(N), .IDW(IDW)) u_done_dec (
        .valid_i (done_valid),
        .id_i    (done_id),
        .hit_o   (done_hit)
    );

    irq_enable_bank #(.N(N)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .en_o  (enable_o)
    );

    generate
        for (genvar k = 0; k < N; k++) begin : g_line
            irq_line_fsm u_fsm (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_i  (irq_req[k]),
                .set_i  (pend_set[k]),
                .clr_i  (pend_clr[k]),
                .ack_i  (ack_hit[k]),
                .done_i (done_hit[k]),
                .pend_o (pending_o[k]),
                .act_o  (active_o[k])
            );
        end
    endgenerate

    assign ready_o = pending_o & enable_o;
endmodule

// File: rtl/irq_pend_tracker_chk.sv
`timescale 1ns/1ps
module irq_pend_tracker_chk #(
    parameter int N   = 32,
    parameter int IDW = $clog2(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   irq_req,
    input logic [N-1:0]   en_clr,
    input logic [N-1:0]   pend_clr,
    input logic           ack_valid,
    input logic [IDW-1:0] ack_id,
    input logic           done_valid,
    input logic [IDW-1:0] done_id,
    input logic [N-1:0]   pending_o,
    input logic [N-1:0]   active_o,
    input logic [N-1:0]   ready_o
);
    assert_enclr_blocks_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr) |=> ((ready_o & $past(en_clr)) == '0));

    assert_req_arms_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |=> (($past(irq_req & ~active_o & ~pend_clr) & ~pending_o) == '0));

    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_clr) |=> ((pending_o & $past(pend_clr)) == '0));

    assert_ack_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && pending_o[ack_id] && !active_o[ack_id] && !pend_clr[ack_id])
        |=> (active_o[$past(ack_id)] && !pending_o[$past(ack_id)]));

    assert_active_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_valid |=> (($past(active_o) & ~active_o) == '0));

    assert_done_exits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && active_o[done_id]) |=> !active_o[$past(done_id)]);
endmodule

bind irq_pend_tracker irq_pend_tracker_chk #(.N(N), .IDW(IDW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .en_clr     (en_clr),
    .pend_clr   (pend_clr),
    .ack_valid  (ack_valid),
    .ack_id     (ack_id),
    .done_valid (done_valid),
    .done_id    (done_id),
    .pending_o  (pending_o),
    .active_o   (active_o),
    .ready_o    (ready_o)
);

// File: tb/irq_pend_tracker_test.sv
`timescale 1ns/1ps
module irq_pend_tracker_test;
    localparam int N   = 32;
    localparam int IDW = 5;
    localparam int L   = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq_req = '0, en_set = '0, en_clr = '0, pend_set = '0, pend_clr = '0;
    logic           ack_valid = 1'b0, done_valid = 1'b0;
    logic [IDW-1:0] ack_id = '0, done_id = '0;
    logic [N-1:0]   enable_o, pending_o, active_o, ready_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_pend_tracker #(.N(N), .IDW(IDW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en_set(en_set), .en_clr(en_clr),
        .pend_set(pend_set), .pend_clr(pend_clr), .ack_valid(ack_valid), .ack_id(ack_id),
        .done_valid(done_valid), .done_id(done_id), .enable_o(enable_o),
        .pending_o(pending_o), .active_o(active_o), .ready_o(ready_o)
    );

    typedef struct packed {
        logic           req;
        logic           pset;
        logic           pclr;
        logic           ack;
        logic [IDW-1:0] aid;
        logic           done;
        logic           exp_p;
        logic           exp_a;
        logic [3:0]     rq;
    } row_t;

    // Each row is applied to line L for one cycle; the expectation is after that edge.
    localparam row_t TBL [18] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 pulse arms
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 stays after fall
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 second pulse
        '{1'b0, 1'b0, 1'b0, 1'b1, 5'd5, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 entry
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 single service
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 edge while active
        '{1'b1, 1'b0, 1'b1, 1'b0, 5'd5, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 clear while active
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 held level ignored
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 exit re-arms
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 pending kept
        '{1'b0, 1'b0, 1'b1, 1'b0, 5'd5, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 clear before service
        '{1'b0, 1'b1, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 software set
        '{1'b0, 1'b0, 1'b0, 1'b1, 5'd5, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 entry
        '{1'b0, 1'b1, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 set while active
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'd5, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 exit keeps pending
        '{1'b1, 1'b0, 1'b1, 1'b0, 5'd5, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 clear beats request
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 re-armed next cycle
        '{1'b0, 1'b0, 1'b0, 1'b1, 5'd6, 1'b0, 1'b1, 1'b0, 4'd7}   // R7 other id ignored
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        irq_req = '0; en_set = '0; en_clr = '0; pend_set = '0; pend_clr = '0;
        ack_valid = 1'b0; done_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #12;
        // R1 reset state
        check("R1 enable", enable_o, '0);
        check("R1 pending", pending_o, '0);
        check("R1 active", active_o, '0);
        check("R1 ready", ready_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 enable line L
        @(negedge clk);
        en_set = N'(1) << L;
        step();
        check("R2 enable set", enable_o, N'(1) << L);
        idle_inputs();

        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            irq_req    = N'(TBL[i].req) << L;
            pend_set   = N'(TBL[i].pset) << L;
            pend_clr   = N'(TBL[i].pclr) << L;
            ack_valid  = TBL[i].ack;
            ack_id     = TBL[i].aid;
            done_valid = TBL[i].done;
            done_id    = IDW'(L);
            step();
            check($sformatf("R%0d row %0d pending", TBL[i].rq, i), pending_o, N'(TBL[i].exp_p) << L);
            check($sformatf("R%0d row %0d active", TBL[i].rq, i), active_o, N'(TBL[i].exp_a) << L);
        end
        idle_inputs();
        step();

        // R2 ready follows pending and enable; disabling keeps pending
        check("R2 ready", ready_o, N'(1) << L);
        @(negedge clk);
        en_clr = N'(1) << L;
        step();
        check("R2 ready after disable", ready_o, '0);
        check("R2 pending unaffected", pending_o, N'(1) << L);
        @(negedge clk);
        en_clr = N'(1) << L;
        en_set = N'(3) << L;
        step();
        check("R2 clear wins", enable_o, N'(1) << (L + 1));
        idle_inputs();

        // R7 ack on non-pending line
        @(negedge clk);
        ack_valid = 1'b1; ack_id = IDW'(20);
        step();
        check("R7 ack non-pending", active_o, '0);
        idle_inputs();

        // R3 all lines pulsed at once
        @(negedge clk);
        irq_req = '1;
        step();
        check("R3 all lines", pending_o, '1);
        idle_inputs();
        step();
        check("R3 held after pulse", pending_o, '1);

        // R9 exit with request low leaves line idle
        @(negedge clk);
        ack_valid = 1'b1; ack_id = IDW'(31);
        step();
        check("R7 line 31 active", active_o, N'(1) << 31);
        @(negedge clk);
        ack_valid = 1'b0; done_valid = 1'b1; done_id = IDW'(31);
        step();
        check("R9 exit clears active", active_o, '0);
        check("R9 no re-arm", pending_o[31], 1'b0);
        idle_inputs();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule